// File: doc/BRIEF.md
# Full-Map Coherence Directory Home Controller

This block is the home-node side of a directory-based coherence scheme for a small group of caching nodes. For every memory line it holds one entry: a bit per node that marks the caches holding a copy, and a modified flag that marks a line held writable by exactly one cache. Requesting nodes send read-miss and write-miss requests on a valid/ready request channel. The home answers on a valid/ready response channel with line data, the identity of the owning node, a fetch (recall) addressed to the owner, or an invalidation addressed to a sharer. Acknowledgements and owner writebacks come back on a third, always-accepting inbound channel. Line data sits in a one-cycle synchronous array inside the block.

Only one transaction is open at a time. While it runs, the request channel is held off, so two requests to the same line can never overlap. A mode input picks how a read of a modified line is served. In the first mode the home tells the requester who the owner is and waits for the owner's writeback. In the second mode the home fetches the line from the owner itself and forwards the data.

Top module: `dirctl_home`

## Requirements
- R1: After reset every entry is empty: no node is marked as a holder and the modified flag is clear. A first write miss to any line therefore gets a data response with an empty sharer list.
- R2: A read miss to an unmodified line gets a DATA response (kind code 0) to the requester, carrying the memory contents of the line. The requester is then added to the line's holders.
- R3: In owner-reply mode (`fetch_via_home` low), a read miss to a modified line gets an OWNER response (kind code 1) to the requester. `rsp_owner` carries the owning node, and no data response follows.
- R4: A writeback (`in_wb` high) from the owner of the open line stores its data into memory and clears the modified flag. The holders become exactly the owner and the requester, and later DATA responses for that line carry the written value.
- R5: In forward mode (`fetch_via_home` high), a read miss to a modified line first gets a FETCH message (kind code 2) addressed to the owner. After the owner's writeback, a DATA response carrying the written-back data goes to the requester.
- R6: A write miss to an unmodified line gets a DATA response to the requester. Its `rsp_nodes` field lists every other holder, with bit i standing for node i. One INVAL message (kind code 3) then goes to each listed holder, in ascending node order, and never to the requester.
- R7: A write miss completes only when the number of acknowledgements (`in_wb` low) for the line equals the number of INVAL messages sent. Until then `req_ready` stays low. Afterwards the requester is the only holder and the modified flag is set.
- R8: A write miss to a line modified by another node sends a FETCH to the owner. After the writeback it sends a DATA response to the requester with the written-back data and `rsp_nodes` holding only the owner's bit. It then sends an INVAL to the owner and, after the owner's acknowledgement, makes the requester the sole modified holder.
- R9: `req_ready` is high only when no transaction is open. Inbound messages that name another line, or a writeback from a node other than the owner, change nothing.
- R10: A response that is offered but not yet accepted keeps its kind, destination, node list and data unchanged until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_via_home | input | 1 | 0: reply with owner id on modified read; 1: home fetches and forwards |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_line | input | LW | Line index of the request |
| req_src | input | NW | Requesting node |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | 0 DATA, 1 OWNER, 2 FETCH, 3 INVAL |
| rsp_line | output | LW | Line the response refers to |
| rsp_dst | output | NW | Destination node |
| rsp_owner | output | NW | Owning node (OWNER responses) |
| rsp_nodes | output | NODES | Sharer list (DATA responses to write misses) |
| rsp_data | output | DW | Line data (DATA responses) |
| in_valid | input | 1 | Inbound acknowledgement or writeback present |
| in_wb | input | 1 | 1 = writeback with data, 0 = invalidation acknowledgement |
| in_line | input | LW | Line of the inbound message |
| in_src | input | NW | Sending node |
| in_data | input | DW | Writeback data |

## Verification
A corrupted entry shows up at the next request for that line. A lost holder bit leaves a node out of the sharer list and the INVAL sequence of the next write miss. A stuck modified flag turns a plain data response into an OWNER or FETCH message. Any of these is visible within the first response of that transaction. A miscounted acknowledgement shows as `req_ready` rising before the last acknowledgement, or never rising, a few cycles after the last INVAL is taken.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;
  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_OWNER = 2'd1,
    RSP_FETCH = 2'd2,
    RSP_INVAL = 2'd3
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_RESP, ST_INV, ST_WACK, ST_WWB, ST_FIN
  } home_state_e;
endpackage

// File: rtl/dirctl_entries.sv
module dirctl_entries #(
  parameter int LINES = 16,
  parameter int EW    = 5,
  localparam int LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_line,
  output logic [EW-1:0] rd_ent,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [EW-1:0] wr_ent
);
  logic [EW-1:0] ent_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_line] <= wr_ent;
    end
  end

  assign rd_ent = ent_q[rd_line];
endmodule

// File: rtl/dirctl_linemem.sv
module dirctl_linemem #(
  parameter int LINES = 16,
  parameter int DW    = 16,
  localparam int LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [LW-1:0] ra,
  output logic [DW-1:0] rq,
  input  logic          we,
  input  logic [LW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/dirctl_lowbit.sv
module dirctl_lowbit #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dirctl_home.sv
module dirctl_home
  import dirctl_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 16,
  parameter int DW    = 16,
  localparam int NW   = $clog2(NODES),
  localparam int LW   = $clog2(LINES),
  localparam int EW   = NODES + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_via_home,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [LW-1:0]    req_line,
  input  logic [NW-1:0]    req_src,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_kind,
  output logic [LW-1:0]    rsp_line,
  output logic [NW-1:0]    rsp_dst,
  output logic [NW-1:0]    rsp_owner,
  output logic [NODES-1:0] rsp_nodes,
  output logic [DW-1:0]    rsp_data,
  input  logic             in_valid,
  input  logic             in_wb,
  input  logic [LW-1:0]    in_line,
  input  logic [NW-1:0]    in_src,
  input  logic [DW-1:0]    in_data
);
  home_state_e state, after_st;
  logic             cur_write;
  logic [LW-1:0]    cur_line;
  logic [NW-1:0]    cur_src, owner_q;
  logic [NODES-1:0] pend;
  logic [NW:0]      sent, acks;

  logic [EW-1:0]    ent, dir_wdata;
  logic             dir_we;
  logic [DW-1:0]    mem_q;
  logic [NW-1:0]    own_idx, pend_idx;
  logic [NODES-1:0] src_bit, own_bit, sharers, pend_left;
  logic             wb_hit, accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rsp_line  = cur_line;
  assign src_bit   = NODES'(1) << cur_src;
  assign own_bit   = NODES'(1) << owner_q;
  assign sharers   = ent[NODES-1:0] & ~src_bit;
  assign pend_left = pend & ~(NODES'(1) << pend_idx);
  assign wb_hit    = (state == ST_WWB) && in_valid && in_wb &&
                     (in_line == cur_line) && (in_src == owner_q);

  dirctl_entries #(.LINES(LINES), .EW(EW)) u_entries (
    .clk(clk), .rst(rst), .rd_line(cur_line), .rd_ent(ent),
    .wr_en(dir_we), .wr_line(cur_line), .wr_ent(dir_wdata)
  );

  dirctl_linemem #(.LINES(LINES), .DW(DW)) u_mem (
    .clk(clk), .re(accept), .ra(req_line), .rq(mem_q),
    .we(wb_hit), .wa(cur_line), .wd(in_data)
  );

  dirctl_lowbit #(.N(NODES)) u_pick_own  (.vec(ent[NODES-1:0]), .idx(own_idx));
  dirctl_lowbit #(.N(NODES)) u_pick_pend (.vec(pend), .idx(pend_idx));

  always_comb begin
    dir_we    = 1'b0;
    dir_wdata = '0;
    if (state == ST_LOOK && !cur_write && !ent[NODES]) begin
      dir_we    = 1'b1;
      dir_wdata = {1'b0, ent[NODES-1:0] | src_bit};
    end else if (wb_hit && !cur_write) begin
      dir_we    = 1'b1;
      dir_wdata = {1'b0, own_bit | src_bit};
    end else if (state == ST_FIN) begin
      dir_we    = 1'b1;
      dir_wdata = {1'b1, src_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      after_st  <= ST_IDLE;
      cur_write <= 1'b0;
      cur_line  <= '0;
      cur_src   <= '0;
      owner_q   <= '0;
      pend      <= '0;
      sent      <= '0;
      acks      <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_DATA;
      rsp_dst   <= '0;
      rsp_owner <= '0;
      rsp_nodes <= '0;
      rsp_data  <= '0;
    end else begin
      if (state != ST_IDLE && in_valid && !in_wb && in_line == cur_line)
        acks <= acks + 1'b1;
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_write <= req_write;
          cur_line  <= req_line;
          cur_src   <= req_src;
          acks      <= '0;
          sent      <= '0;
          state     <= ST_LOOK;
        end
        ST_LOOK: begin
          owner_q   <= own_idx;
          rsp_valid <= 1'b1;
          rsp_nodes <= '0;
          state     <= ST_RESP;
          if (!cur_write && !ent[NODES]) begin
            rsp_kind <= RSP_DATA;
            rsp_dst  <= cur_src;
            rsp_data <= mem_q;
            after_st <= ST_IDLE;
          end else if (ent[NODES] && own_idx != cur_src) begin
            if (!cur_write && !fetch_via_home) begin
              rsp_kind  <= RSP_OWNER;
              rsp_dst   <= cur_src;
              rsp_owner <= own_idx;
            end else begin
              rsp_kind <= RSP_FETCH;
              rsp_dst  <= own_idx;
            end
            after_st <= ST_WWB;
          end else begin
            rsp_kind  <= RSP_DATA;
            rsp_dst   <= cur_src;
            rsp_data  <= mem_q;
            rsp_nodes <= sharers;
            pend      <= sharers;
            after_st  <= (sharers == '0) ? ST_FIN : ST_INV;
          end
        end
        ST_RESP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          state     <= after_st;
        end
        ST_INV: begin
          rsp_kind  <= RSP_INVAL;
          rsp_dst   <= pend_idx;
          rsp_nodes <= '0;
          rsp_valid <= 1'b1;
          pend      <= pend_left;
          sent      <= sent + 1'b1;
          after_st  <= (pend_left == '0) ? ST_WACK : ST_INV;
          state     <= ST_RESP;
        end
        ST_WACK: if (acks == sent) state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        ST_WWB: if (wb_hit) begin
          if (!cur_write && !fetch_via_home) begin
            state <= ST_IDLE;
          end else begin
            rsp_kind  <= RSP_DATA;
            rsp_dst   <= cur_src;
            rsp_data  <= in_data;
            rsp_nodes <= cur_write ? own_bit : '0;
            pend      <= cur_write ? own_bit : '0;
            after_st  <= cur_write ? ST_INV : ST_IDLE;
            rsp_valid <= 1'b1;
            state     <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dirctl_home_chk.sv
module dirctl_home_chk #(
  parameter int NODES = 4,
  parameter int DW    = 16,
  localparam int NW   = $clog2(NODES)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_kind,
  input logic [NW-1:0]    rsp_dst,
  input logic [NW-1:0]    rsp_owner,
  input logic [NODES-1:0] rsp_nodes,
  input logic [DW-1:0]    rsp_data,
  input logic [NW-1:0]    cur_src,
  input logic             dir_we,
  input logic [NODES:0]   dir_wdata,
  input logic [NW:0]      acks,
  input logic [NW:0]      sent
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) &&
      $stable(rsp_dst) && $stable(rsp_nodes) && $stable(rsp_data));

  p_inval_not_req_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 2'd3 |-> rsp_dst != cur_src);

  p_list_excl_req_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 2'd0 |-> rsp_nodes[rsp_dst] == 1'b0);

  p_owner_other_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 2'd1 |-> rsp_owner != rsp_dst);

  p_dirty_single_r7: assert property (@(posedge clk) disable iff (rst)
    dir_we && dir_wdata[NODES] |-> $countones(dir_wdata[NODES-1:0]) == 1);

  p_ack_bound_r7: assert property (@(posedge clk) disable iff (rst)
    acks <= sent);
endmodule

bind dirctl_home dirctl_home_chk #(.NODES(NODES), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
  .rsp_owner(rsp_owner), .rsp_nodes(rsp_nodes), .rsp_data(rsp_data),
  .cur_src(cur_src), .dir_we(dir_we), .dir_wdata(dir_wdata),
  .acks(acks), .sent(sent)
);

// File: tb/dirctl_home_tb.sv
module dirctl_home_tb;
  localparam int NODES = 4;
  localparam int LINES = 16;
  localparam int DW    = 16;
  localparam int NW    = $clog2(NODES);
  localparam int LW    = $clog2(LINES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_via_home = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [NW-1:0] req_src = '0;
  logic req_ready, rsp_valid;
  logic rsp_ready = 1'b0;
  logic [1:0] rsp_kind;
  logic [LW-1:0] rsp_line;
  logic [NW-1:0] rsp_dst, rsp_owner;
  logic [NODES-1:0] rsp_nodes;
  logic [DW-1:0] rsp_data;
  logic in_valid = 1'b0, in_wb = 1'b0;
  logic [LW-1:0] in_line = '0;
  logic [NW-1:0] in_src = '0;
  logic [DW-1:0] in_data = '0;

  int errors = 0;
  int checks = 0;

  bit [NODES-1:0] m_pres [LINES];
  bit             m_dirty[LINES];
  bit [DW-1:0]    m_mem  [LINES];
  bit             m_known[LINES];

  always #5 clk = ~clk;

  dirctl_home #(.NODES(NODES), .LINES(LINES), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .fetch_via_home(fetch_via_home),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_src(req_src), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_line(rsp_line),
    .rsp_dst(rsp_dst), .rsp_owner(rsp_owner), .rsp_nodes(rsp_nodes),
    .rsp_data(rsp_data), .in_valid(in_valid), .in_wb(in_wb),
    .in_line(in_line), .in_src(in_src), .in_data(in_data)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int low_node(input bit [NODES-1:0] v);
    for (int i = NODES - 1; i >= 0; i--) if (v[i]) low_node = i;
    if (v == '0) low_node = 0;
  endfunction

  task automatic send_req(input bit w, input int line, input int src);
    int n = 0;
    @(negedge clk);
    req_write = w; req_line = LW'(line); req_src = NW'(src); req_valid = 1'b1;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rsp(output logic [1:0] k, output int dst, output int own,
                         output logic [NODES-1:0] nodes, output logic [DW-1:0] d);
    int n = 0;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    k = rsp_kind; dst = int'(rsp_dst); own = int'(rsp_owner);
    nodes = rsp_nodes; d = rsp_data;
    repeat ($urandom % 3) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic send_in(input bit wb, input int line, input int src,
                         input logic [DW-1:0] d);
    in_wb = wb; in_line = LW'(line); in_src = NW'(src); in_data = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    chk(req_ready, "R9 ready after transaction", req_ready, 1);
  endtask

  task automatic expect_data(input int src, input int line,
                             input bit [NODES-1:0] nodes, input string tag);
    logic [1:0] k; int dst, own; logic [NODES-1:0] nd; logic [DW-1:0] d;
    get_rsp(k, dst, own, nd, d);
    chk(k == 2'd0 && dst == src, {tag, " data kind/dst"}, {k, 8'(dst)}, {2'd0, 8'(src)});
    chk(nd == nodes, {tag, " sharer list"}, nd, nodes);
    if (m_known[line]) chk(d == m_mem[line], {tag, " data value"}, d, m_mem[line]);
  endtask

  task automatic inval_round(input int line, input bit [NODES-1:0] sh,
                             input string tag);
    logic [1:0] k; int dst, own; logic [NODES-1:0] nd; logic [DW-1:0] d;
    int left = $countones(sh);
    for (int i = 0; i < NODES; i++) begin
      if (sh[i]) begin
        get_rsp(k, dst, own, nd, d);
        chk(k == 2'd3 && dst == i, {tag, " inval order"}, {k, 8'(dst)}, {2'd3, 8'(i)});
        left--;
        if (left == 0) begin
          repeat (2) @(negedge clk);
          chk(!req_ready, "R7 busy before last ack", req_ready, 0);
          send_in(1'b0, (line + 1) % LINES, i, '0);
          @(negedge clk);
          chk(!req_ready, "R9 other-line ack ignored", req_ready, 0);
        end
        send_in(1'b0, line, i, '0);
      end
    end
  endtask

  task automatic txn(input bit w, input int line, input int src, input bit mode);
    logic [1:0] k; int dst, own; logic [NODES-1:0] nd; logic [DW-1:0] d;
    logic [DW-1:0] wbd;
    int o;
    bit [NODES-1:0] sbit;
    fetch_via_home = mode;
    sbit = NODES'(1) << src;
    o = low_node(m_pres[line]);
    wbd = DW'($urandom);
    send_req(w, line, src);
    if (!w && !m_dirty[line]) begin
      expect_data(src, line, '0, "R2");
      m_pres[line] |= sbit;
    end else if (m_dirty[line] && o != src) begin
      get_rsp(k, dst, own, nd, d);
      if (!w && !mode) begin
        chk(k == 2'd1 && dst == src, "R3 owner reply kind/dst", {k, 8'(dst)}, {2'd1, 8'(src)});
        chk(own == o, "R3 owner id", own, o);
      end else begin
        chk(k == 2'd2 && dst == o, w ? "R8 recall to owner" : "R5 fetch to owner",
            {k, 8'(dst)}, {2'd2, 8'(o)});
      end
      send_in(1'b1, line, (o + 1) % NODES, ~wbd);
      if (!w && !mode) begin
        @(negedge clk);
        chk(!req_ready, "R9 non-owner writeback ignored", req_ready, 0);
      end
      send_in(1'b1, line, o, wbd);
      m_mem[line] = wbd; m_known[line] = 1'b1;
      if (!w) begin
        if (mode) expect_data(src, line, '0, "R5");
        m_dirty[line] = 1'b0;
        m_pres[line] = sbit | (NODES'(1) << o);
      end else begin
        expect_data(src, line, NODES'(1) << o, "R8");
        inval_round(line, NODES'(1) << o, "R8");
        m_dirty[line] = 1'b1; m_pres[line] = sbit;
      end
    end else begin
      expect_data(src, line, m_pres[line] & ~sbit, "R6");
      inval_round(line, m_pres[line] & ~sbit, "R6");
      m_dirty[line] = 1'b1; m_pres[line] = sbit;
    end
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd2024);
    for (int i = 0; i < LINES; i++) begin
      m_pres[i] = '0; m_dirty[i] = 1'b0; m_known[i] = 1'b0; m_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 reset idle", {req_ready, rsp_valid}, 2'b10);

    txn(1'b1, 5, 1, 1'b0);   // R1: fresh line, empty list
    txn(1'b0, 5, 2, 1'b0);   // R3, R4: owner reply, writeback
    txn(1'b0, 5, 3, 1'b1);   // R2 clean read with known data
    txn(1'b0, 5, 0, 1'b0);
    txn(1'b1, 5, 0, 1'b0);   // R6, R7: three invalidations
    txn(1'b0, 5, 2, 1'b1);   // R5 forward
    txn(1'b1, 5, 3, 1'b0);
    txn(1'b1, 5, 1, 1'b1);   // R8 recall from node 3
    txn(1'b1, 9, 2, 1'b0);   // R1 other line still empty

    for (int n = 0; n < 300; n++) begin
      int line, src;
      bit w, mode;
      w = 1'($urandom);
      mode = 1'($urandom);
      line = $urandom % 4;
      src = $urandom % NODES;
      if (!w && m_dirty[line] && low_node(m_pres[line]) == src)
        src = (src + 1) % NODES;
      txn(w, line, src, mode);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule